// File: doc/BRIEF.md
# Three-Multiplier Pipelined Complex Multiplier

This block multiplies two signed complex numbers, X and Y, each carried as a 32-bit signed real part and a 32-bit signed imaginary part. It returns the product as a 64-bit signed real part and a 64-bit signed imaginary part. It needs three hardware multipliers where the direct form needs four.

Three widened pre-adders come first. They form xr+xi, xi-xr and yr+yi at 33 bits. The product xr*(yr+yi) is then shared between both outputs. The real result is that shared product minus yi*(xr+xi). The imaginary result is the shared product plus yr*(xi-xr).

Operands arrive on a valid-qualified stream, and a new pair may be accepted on every clock. Each result appears exactly four cycles after its operands, together with its own valid flag. There is no stall path. Rounding, saturation and accumulation are left to the logic around the block.

Top module: `cmul3_top`

## Requirements
- R1: While rst_ni is low, out_valid_o is 0. After reset is released, out_valid_o stays 0 until a pair accepted after the release has travelled the full latency.
- R2: out_valid_o equals in_valid_i as sampled four rising clock edges earlier. Gaps in the input stream reappear at the output, unchanged, four cycles later.
- R3: When out_valid_o is 1, p_re_o holds the low 64 bits, in two's complement, of xr*yr - xi*yi for the pair sampled four edges earlier.
- R4: When out_valid_o is 1, p_im_o holds the low 64 bits, in two's complement, of xr*yi + xi*yr for the pair sampled four edges earlier.
- R5: A new operand pair is accepted on every cycle in which in_valid_i is 1. A stream of back-to-back pairs produces back-to-back results, each one correct.
- R6: The pre-addition cannot overflow for any operand values. Operands at the extremes give exact results, for example xr=xi=yr=yi=2^31-1, or xr=-2^31 with xi=2^31-1.
- R7: With all four parts at -2^31, p_re_o is 0. The exact imaginary value is 2^63, which does not fit in 64 signed bits, so p_im_o is 64'h8000_0000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair on the inputs is valid this cycle |
| x_re_i | input | 32 | Real part of X, signed |
| x_im_i | input | 32 | Imaginary part of X, signed |
| y_re_i | input | 32 | Real part of Y, signed |
| y_im_i | input | 32 | Imaginary part of Y, signed |
| out_valid_o | output | 1 | Product on the outputs is valid |
| p_re_o | output | 64 | Real part of the product, signed |
| p_im_o | output | 64 | Imaginary part of the product, signed |

## Verification
Because the initiation interval is 1, a new operand pair is taken in during the same cycle that an earlier result leaves the pipeline. Long runs with in_valid_i held high keep all four stages full, so every stage is loaded while the previous stage hands its value on. Interleaved runs with random valid gaps show whether a bubble moves through in step with the data.

Every output cycle is judged against a bench model that uses the direct four-multiplier formula at 128 bits, reduced to 64 bits. The model also keeps a four-deep record of the expected valid flag.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;
  parameter int unsigned DEF_DW = 32;
  localparam int unsigned N_MUL = 3;
  // multiplier lane order: shared, real-side, imag-side
  localparam int unsigned L_SHR = 0;
  localparam int unsigned L_RE  = 1;
  localparam int unsigned L_IM  = 2;
endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd #(
  parameter int unsigned DW = cmul3_pkg::DEF_DW,
  localparam int unsigned PW = DW + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 v_i,
  input  logic signed [DW-1:0] xr_i,
  input  logic signed [DW-1:0] xi_i,
  input  logic signed [DW-1:0] yr_i,
  input  logic signed [DW-1:0] yi_i,
  output logic                 v_o,
  output logic signed [PW-1:0] sx_o,   // xr + xi
  output logic signed [PW-1:0] dx_o,   // xi - xr
  output logic signed [PW-1:0] sy_o,   // yr + yi
  output logic signed [DW-1:0] xr_o,
  output logic signed [DW-1:0] yr_o,
  output logic signed [DW-1:0] yi_o
);
  logic signed [PW-1:0] sx_d, dx_d, sy_d;

  // sign-extend before the add so the carry has room
  always_comb begin
    sx_d = PW'(xr_i) + PW'(xi_i);
    dx_d = PW'(xi_i) - PW'(xr_i);
    sy_d = PW'(yr_i) + PW'(yi_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o  <= 1'b0;
      sx_o <= '0;
      dx_o <= '0;
      sy_o <= '0;
      xr_o <= '0;
      yr_o <= '0;
      yi_o <= '0;
    end else begin
      v_o  <= v_i;
      sx_o <= sx_d;
      dx_o <= dx_d;
      sy_o <= sy_d;
      xr_o <= xr_i;
      yr_o <= yr_i;
      yi_o <= yi_i;
    end
  end
endmodule

// File: rtl/cmul3_mult.sv
module cmul3_mult #(
  parameter int unsigned DW = cmul3_pkg::DEF_DW,
  localparam int unsigned PW = DW + 1,
  localparam int unsigned MW = DW + PW,
  localparam int unsigned NM = cmul3_pkg::N_MUL
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   v_i,
  input  logic [NM-1:0][DW-1:0]  a_i,
  input  logic [NM-1:0][PW-1:0]  b_i,
  output logic                   v_o,
  output logic [NM-1:0][MW-1:0]  p_o
);
  for (genvar k = 0; k < NM; k++) begin : g_lane
    logic signed [MW-1:0] prod_d;
    always_comb prod_d = MW'($signed(a_i[k])) * MW'($signed(b_i[k]));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) p_o[k] <= '0;
      else         p_o[k] <= prod_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_o <= 1'b0;
    else         v_o <= v_i;
  end
endmodule

// File: rtl/cmul3_post.sv
module cmul3_post #(
  parameter int unsigned DW = cmul3_pkg::DEF_DW,
  localparam int unsigned MW = 2 * DW + 1,
  localparam int unsigned OW = 2 * DW,
  localparam int unsigned NM = cmul3_pkg::N_MUL
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  v_i,
  input  logic [NM-1:0][MW-1:0] p_i,
  output logic                  v_o,
  output logic [OW-1:0]         re_o,
  output logic [OW-1:0]         im_o
);
  logic signed [MW-1:0] shr, mre, mim;
  logic [OW-1:0] re_d, im_d;

  always_comb begin
    shr  = $signed(p_i[cmul3_pkg::L_SHR]);
    mre  = $signed(p_i[cmul3_pkg::L_RE]);
    mim  = $signed(p_i[cmul3_pkg::L_IM]);
    // keep low OW bits; modular result
    re_d = OW'(shr - mre);
    im_d = OW'(shr + mim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o  <= 1'b0;
      re_o <= '0;
      im_o <= '0;
    end else begin
      v_o  <= v_i;
      re_o <= re_d;
      im_o <= im_d;
    end
  end
endmodule

// File: rtl/cmul3_top.sv
module cmul3_top #(
  parameter int unsigned DW = cmul3_pkg::DEF_DW,
  localparam int unsigned PW = DW + 1,
  localparam int unsigned MW = 2 * DW + 1,
  localparam int unsigned OW = 2 * DW,
  localparam int unsigned NM = cmul3_pkg::N_MUL,
  localparam int unsigned LAT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] x_re_i,
  input  logic [DW-1:0] x_im_i,
  input  logic [DW-1:0] y_re_i,
  input  logic [DW-1:0] y_im_i,
  output logic          out_valid_o,
  output logic [OW-1:0] p_re_o,
  output logic [OW-1:0] p_im_o
);
  import cmul3_pkg::*;

  // stage 1: operand capture
  logic                 v_q;
  logic signed [DW-1:0] xr_q, xi_q, yr_q, yi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q  <= 1'b0;
      xr_q <= '0;
      xi_q <= '0;
      yr_q <= '0;
      yi_q <= '0;
    end else begin
      v_q  <= in_valid_i;
      xr_q <= $signed(x_re_i);
      xi_q <= $signed(x_im_i);
      yr_q <= $signed(y_re_i);
      yi_q <= $signed(y_im_i);
    end
  end

  // stage 2: pre-add
  logic                 v_pa;
  logic signed [PW-1:0] sx, dx, sy;
  logic signed [DW-1:0] xr_pa, yr_pa, yi_pa;

  cmul3_preadd #(.DW(DW)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (v_q),
    .xr_i  (xr_q),
    .xi_i  (xi_q),
    .yr_i  (yr_q),
    .yi_i  (yi_q),
    .v_o   (v_pa),
    .sx_o  (sx),
    .dx_o  (dx),
    .sy_o  (sy),
    .xr_o  (xr_pa),
    .yr_o  (yr_pa),
    .yi_o  (yi_pa)
  );

  // stage 3: three multipliers
  logic [NM-1:0][DW-1:0] mul_a;
  logic [NM-1:0][PW-1:0] mul_b;
  logic [NM-1:0][MW-1:0] mul_p;
  logic                  v_m;

  always_comb begin
    mul_a[L_SHR] = xr_pa;
    mul_b[L_SHR] = sy;
    mul_a[L_RE]  = yi_pa;
    mul_b[L_RE]  = sx;
    mul_a[L_IM]  = yr_pa;
    mul_b[L_IM]  = dx;
  end

  cmul3_mult #(.DW(DW)) u_mul (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (v_pa),
    .a_i   (mul_a),
    .b_i   (mul_b),
    .v_o   (v_m),
    .p_o   (mul_p)
  );

  // stage 4: combine
  cmul3_post #(.DW(DW)) u_post (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .v_i   (v_m),
    .p_i   (mul_p),
    .v_o   (out_valid_o),
    .re_o  (p_re_o),
    .im_o  (p_im_o)
  );

  // ---------------- checks ----------------
  localparam int unsigned RW = 2 * DW + 2;
  logic [2:0] since_rst;
  logic       in_d1, in_d2, in_d3, in_d4;
  logic signed [RW-1:0] dir_re, dir_im;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= '0;
      {in_d1, in_d2, in_d3, in_d4} <= '0;
    end else begin
      if (since_rst != 3'(LAT)) since_rst <= since_rst + 3'd1;
      {in_d1, in_d2, in_d3, in_d4} <= {in_valid_i, in_d1, in_d2, in_d3};
    end
  end

  // direct four-multiplier form on captured operands
  always_comb begin
    dir_re = RW'(xr_q) * RW'(yr_q) - RW'(xi_q) * RW'(yi_q);
    dir_im = RW'(xr_q) * RW'(yi_q) + RW'(xi_q) * RW'(yr_q);
  end

  AST_NO_EARLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < 3'(LAT)) |-> !out_valid_o);  // R1
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'(LAT)) |-> (out_valid_o == in_d4));  // R2
  AST_REAL_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (p_re_o == OW'($past(dir_re, 3))));  // R3
  AST_IMAG_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (p_im_o == OW'($past(dir_im, 3))));  // R4
endmodule

// File: tb/sim_cmul3_top.sv
module sim_cmul3_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] x_re_i = '0, x_im_i = '0, y_re_i = '0, y_im_i = '0;
  logic        out_valid_o;
  logic [63:0] p_re_o, p_im_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  int since = 0;

  logic        exp_v  [8];
  logic [63:0] exp_re [8];
  logic [63:0] exp_im [8];
  string       tag_re [8];
  string       tag_im [8];

  always #5 clk_i = ~clk_i;

  cmul3_top u0 (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .x_re_i     (x_re_i),
    .x_im_i     (x_im_i),
    .y_re_i     (y_re_i),
    .y_im_i     (y_im_i),
    .out_valid_o(out_valid_o),
    .p_re_o     (p_re_o),
    .p_im_o     (p_im_o)
  );

  function automatic logic [63:0] f_re(logic [31:0] a, logic [31:0] b,
                                       logic [31:0] c, logic [31:0] d);
    logic signed [127:0] r;
    r = 128'($signed(a)) * 128'($signed(c)) - 128'($signed(b)) * 128'($signed(d));
    return r[63:0];
  endfunction

  function automatic logic [63:0] f_im(logic [31:0] a, logic [31:0] b,
                                       logic [31:0] c, logic [31:0] d);
    logic signed [127:0] r;
    r = 128'($signed(a)) * 128'($signed(d)) + 128'($signed(b)) * 128'($signed(c));
    return r[63:0];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // called at a falling edge: judge outputs, then drive the next pair
  task automatic step(logic v, logic [31:0] a, logic [31:0] b,
                      logic [31:0] c, logic [31:0] d, string tr, string ti);
    int s, w;
    s = cyc % 8;
    w = (cyc + 4) % 8;
    chk((since < 4) ? "R1" : "R2", 64'(out_valid_o), 64'(exp_v[s]));
    if (exp_v[s]) begin
      chk(tag_re[s], p_re_o, exp_re[s]);
      chk(tag_im[s], p_im_o, exp_im[s]);
    end
    in_valid_i = v;
    x_re_i = a; x_im_i = b; y_re_i = c; y_im_i = d;
    exp_v[w]  = v;
    exp_re[w] = f_re(a, b, c, d);
    exp_im[w] = f_im(a, b, c, d);
    tag_re[w] = tr;
    tag_im[w] = ti;
    @(posedge clk_i);
    @(negedge clk_i);
    cyc++;
    since++;
  endtask

  initial begin
    #(10 * 200000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    for (int i = 0; i < 8; i++) begin
      exp_v[i] = 1'b0; exp_re[i] = '0; exp_im[i] = '0;
      tag_re[i] = "R3"; tag_im[i] = "R4";
    end
    // R1: valid low while reset held, even with input valid high
    in_valid_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R1", 64'(out_valid_o), 64'd0);
    end
    in_valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    since = 0;

    // directed
    step(1, 32'd1, 32'd2, 32'd3, 32'd4, "R3", "R4");
    step(1, 32'd0, 32'd0, 32'd0, 32'd0, "R3", "R4");
    step(1, -32'sd7, 32'd5, 32'd9, -32'sd11, "R3", "R4");
    step(0, 32'hdead_beef, 32'd1, 32'd1, 32'd1, "R2", "R2");
    step(1, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000, "R7", "R7");
    step(1, 32'h7fff_ffff, 32'h7fff_ffff, 32'h7fff_ffff, 32'h7fff_ffff, "R6", "R6");
    step(1, 32'h8000_0000, 32'h7fff_ffff, 32'h8000_0000, 32'h8000_0000, "R6", "R6");
    step(1, 32'h7fff_ffff, 32'h8000_0000, 32'h8000_0000, 32'h7fff_ffff, "R6", "R6");
    step(1, 32'h8000_0000, 32'h8000_0000, 32'h7fff_ffff, 32'h7fff_ffff, "R6", "R6");
    for (int i = 0; i < 5; i++) step(0, '0, '0, '0, '0, "R2", "R2");
    // R7 explicit values after flush
    chk("R7", f_re(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000), 64'd0);
    chk("R7", f_im(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000),
        64'h8000_0000_0000_0000);

    // R5: back-to-back random
    for (int i = 0; i < 400; i++)
      step(1, $urandom, $urandom, $urandom, $urandom, "R5", "R5");
    // R2/R3/R4: random valid gaps
    for (int i = 0; i < 600; i++)
      step(1'($urandom % 2), $urandom, $urandom, $urandom, $urandom, "R3", "R4");
    // corner mix drawn from extremes
    for (int i = 0; i < 100; i++) begin
      logic [31:0] pick [4];
      for (int k = 0; k < 4; k++)
        case ($urandom % 4)
          0: pick[k] = 32'h8000_0000;
          1: pick[k] = 32'h7fff_ffff;
          2: pick[k] = 32'hffff_ffff;
          default: pick[k] = 32'h0000_0000;
        endcase
      step(1, pick[0], pick[1], pick[2], pick[3], "R6", "R6");
    end
    for (int i = 0; i < 6; i++) step(0, '0, '0, '0, '0, "R2", "R2");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule